// File: doc/BRIEF.md
# Serial Channel Status Flags and Interrupt Requests

This block keeps the status flags of one asynchronous serial channel and turns them into interrupt requests. A CPU-side register interface writes bytes to send, reads received bytes, clears sticky error flags and sets three interrupt enables. A core-side set of single-cycle strobes comes from the shifter logic. These strobes report that the transmit shifter took the pending byte, that a transmission has fully ended, and that a received byte is complete, together with its parity and framing status.

The block drives four separate request lines: receive error, receive full, transmit empty and transmit end. It also gives a two-bit code for the highest-priority pending request. Flags change on the clock edge that follows the event. Request lines and the priority code are combinational from the registered flags and enables.

Top module: `sio_status_irq`

## Requirements
- R1: After reset, statusOut bit0 (transmit empty) and bit1 (transmit end) are 1. Bits 2..5 (receive full, overrun, parity error, framing error) are 0. All enables are 0, so no request line is active and irqTopValid is 0.
- R2: A CPU transmit write stores cpuTxData and clears transmit empty on the next edge. A write while transmit empty is 0 replaces the unsent byte. A shiftLoadStb sets transmit empty, and txShiftData always shows the most recently written byte.
- R3: A CPU transmit write clears transmit end. A txDoneStb without a write in the same cycle sets it.
- R4: A rxDoneStb while receive full is 0 stores rxByte in rxData and sets receive full. cpuRxRead clears receive full.
- R5: A rxDoneStb while receive full is 1 and no read occurs in the same cycle sets the overrun flag (bit3). The new byte is discarded and rxData keeps the old byte.
- R6: A byte that is accepted with rxParityErr or rxFrameErr set sets the parity flag (bit4) or framing flag (bit5). The error inputs of a discarded byte are ignored.
- R7: A status write clears each error flag whose bit in statWrData is 0 (bit0 overrun, bit1 parity, bit2 framing). A bit written as 1 leaves its flag unchanged.
- R8: ctrlWrData bit0 enables transmit-empty requests, bit1 enables both receive-full and receive-error requests, and bit2 enables transmit-end requests. Each request line equals its flag (any error flag for receive error) ANDed with its enable.
- R9: irqTopValid is 1 when any request is active. irqTopId gives the highest active request in the order 0 = receive error, 1 = receive full, 2 = transmit empty, 3 = transmit end.
- R10: A transmit write in the same cycle as shiftLoadStb leaves transmit empty at 0. A read in the same cycle as rxDoneStb accepts the new byte, keeps receive full at 1 and does not set overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuTxWrite | input | 1 | CPU writes the transmit data register |
| cpuTxData | input | DATA_W | Byte to transmit |
| cpuRxRead | input | 1 | CPU reads the receive data register |
| statWrite | input | 1 | CPU writes the error-clear field |
| statWrData | input | 3 | Error-clear data: bit0 overrun, bit1 parity, bit2 framing; 0 clears |
| ctrlWrite | input | 1 | CPU writes the enables |
| ctrlWrData | input | 3 | bit0 transmit, bit1 receive, bit2 transmit-end enable |
| shiftLoadStb | input | 1 | Transmit shifter took the pending byte |
| txDoneStb | input | 1 | Transmission fully finished |
| rxDoneStb | input | 1 | Received byte complete |
| rxByte | input | DATA_W | Received byte |
| rxParityErr | input | 1 | Parity error on the completing byte |
| rxFrameErr | input | 1 | Framing error on the completing byte |
| txShiftData | output | DATA_W | Byte offered to the transmit shifter |
| rxData | output | DATA_W | Receive data register |
| statusOut | output | 6 | Flags: txEmpty, txEnd, rxFull, overrun, parity, framing (bit0..5) |
| irqRxErr | output | 1 | Receive error request |
| irqRxFull | output | 1 | Receive full request |
| irqTxEmpty | output | 1 | Transmit empty request |
| irqTxEnd | output | 1 | Transmit end request |
| irqTopValid | output | 1 | Some request is active |
| irqTopId | output | 2 | Code of the highest active request |

## Verification
The hardest situations to reach are same-cycle collisions. These are a byte completing on the cycle the CPU reads the previous one, a CPU write meeting a shifter load, and an overrun that carries error inputs, which must not leave a parity or framing flag. The stimulus reaches them by first filling the receive register without reading it, and then driving the colliding strobes on one cycle. A reference model in the bench tracks every flag, so each collision is compared field by field on the following edge.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int STAT_W  = 6;
  localparam int ST_TXE  = 0;
  localparam int ST_TEND = 1;
  localparam int ST_RXF  = 2;
  localparam int ST_OVR  = 3;
  localparam int ST_PE   = 4;
  localparam int ST_FE   = 5;

  localparam int ERRW_W  = 3;
  localparam int EW_OVR  = 0;
  localparam int EW_PE   = 1;
  localparam int EW_FE   = 2;

  localparam int EN_W    = 3;
  localparam int EN_TX   = 0;
  localparam int EN_RX   = 1;
  localparam int EN_TEND = 2;

  localparam int NSRC    = 4;
  localparam int SRC_W   = $clog2(NSRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_ERR  = 2'd0,
    SRC_RXF  = 2'd1,
    SRC_TXE  = 2'd2,
    SRC_TEND = 2'd3
  } srcId_t;

  typedef struct packed {
    logic txLatch;
    logic rxCapture;
  } dpStrobe_t;
endpackage

// File: rtl/sio_dpath.sv
module sio_dpath
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] cpuTxData,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] txShiftData,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] rxReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg <= '0;
      rxReg <= '0;
    end else begin
      if (strb.txLatch)   txReg <= cpuTxData;
      if (strb.rxCapture) rxReg <= rxByte;
    end
  end

  assign txShiftData = txReg;
  assign rxData      = rxReg;

  // R5: without a capture strobe the receive register holds its byte
  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rxCapture |=> $stable(rxData));

  // R2: a transmit latch presents the written byte on the next cycle
  p_tx_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLatch |=> (txShiftData == $past(cpuTxData)));
endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuTxWrite,
  input  logic              cpuRxRead,
  input  logic              statWrite,
  input  logic [ERRW_W-1:0] statWrData,
  input  logic              ctrlWrite,
  input  logic [EN_W-1:0]   ctrlWrData,
  input  logic              shiftLoadStb,
  input  logic              txDoneStb,
  input  logic              rxDoneStb,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  output dpStrobe_t         strb,
  output logic [STAT_W-1:0] statusOut,
  output logic [NSRC-1:0]   reqVec,
  output logic              topValid,
  output srcId_t            topId
);
  logic txEmpty, txEnd, rxFull, ovrFlag, parFlag, frmFlag;
  logic [EN_W-1:0] enables;
  logic acceptByte;

  assign acceptByte = rxDoneStb && (!rxFull || cpuRxRead);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
      txEnd   <= 1'b1;
      rxFull  <= 1'b0;
      ovrFlag <= 1'b0;
      parFlag <= 1'b0;
      frmFlag <= 1'b0;
      enables <= '0;
    end else begin
      if (cpuTxWrite)        txEmpty <= 1'b0;
      else if (shiftLoadStb) txEmpty <= 1'b1;

      if (cpuTxWrite)     txEnd <= 1'b0;
      else if (txDoneStb) txEnd <= 1'b1;

      if (acceptByte)     rxFull <= 1'b1;
      else if (cpuRxRead) rxFull <= 1'b0;

      if (rxDoneStb && !acceptByte)                ovrFlag <= 1'b1;
      else if (statWrite && !statWrData[EW_OVR])   ovrFlag <= 1'b0;

      if (acceptByte && rxParityErr)               parFlag <= 1'b1;
      else if (statWrite && !statWrData[EW_PE])    parFlag <= 1'b0;

      if (acceptByte && rxFrameErr)                frmFlag <= 1'b1;
      else if (statWrite && !statWrData[EW_FE])    frmFlag <= 1'b0;

      if (ctrlWrite) enables <= ctrlWrData;
    end
  end

  assign strb.txLatch   = cpuTxWrite;
  assign strb.rxCapture = acceptByte;

  always_comb begin
    statusOut          = '0;
    statusOut[ST_TXE]  = txEmpty;
    statusOut[ST_TEND] = txEnd;
    statusOut[ST_RXF]  = rxFull;
    statusOut[ST_OVR]  = ovrFlag;
    statusOut[ST_PE]   = parFlag;
    statusOut[ST_FE]   = frmFlag;
  end

  always_comb begin
    reqVec           = '0;
    reqVec[SRC_ERR]  = enables[EN_RX]   && (ovrFlag || parFlag || frmFlag);
    reqVec[SRC_RXF]  = enables[EN_RX]   && rxFull;
    reqVec[SRC_TXE]  = enables[EN_TX]   && txEmpty;
    reqVec[SRC_TEND] = enables[EN_TEND] && txEnd;
  end

  always_comb begin
    topId = SRC_ERR;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (reqVec[i]) topId = srcId_t'(i);
    end
  end
  assign topValid = |reqVec;

  // R2: a transmit write always leaves transmit-empty low
  p_txwr_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuTxWrite |=> !statusOut[ST_TXE]);

  // R5: a byte arriving on a full, unread register raises overrun
  p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxDoneStb && rxFull && !cpuRxRead) |=> statusOut[ST_OVR]);

  // R7: overrun is sticky until an explicit clear
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[ST_OVR] && !statWrite) |=> statusOut[ST_OVR]);

  // R10: read and completion together keep receive-full set
  p_rd_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxDoneStb && cpuRxRead) |=> (statusOut[ST_RXF] && !$rose(statusOut[ST_OVR])));
endmodule

// File: rtl/sio_status_irq.sv
module sio_status_irq
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuTxWrite,
  input  logic [DATA_W-1:0] cpuTxData,
  input  logic              cpuRxRead,
  input  logic              statWrite,
  input  logic [2:0]        statWrData,
  input  logic              ctrlWrite,
  input  logic [2:0]        ctrlWrData,
  input  logic              shiftLoadStb,
  input  logic              txDoneStb,
  input  logic              rxDoneStb,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  output logic [DATA_W-1:0] txShiftData,
  output logic [DATA_W-1:0] rxData,
  output logic [5:0]        statusOut,
  output logic              irqRxErr,
  output logic              irqRxFull,
  output logic              irqTxEmpty,
  output logic              irqTxEnd,
  output logic              irqTopValid,
  output logic [1:0]        irqTopId
);
  dpStrobe_t       strb;
  logic [NSRC-1:0] reqVec;
  srcId_t          topId;

  sio_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuTxWrite   (cpuTxWrite),
    .cpuRxRead    (cpuRxRead),
    .statWrite    (statWrite),
    .statWrData   (statWrData),
    .ctrlWrite    (ctrlWrite),
    .ctrlWrData   (ctrlWrData),
    .shiftLoadStb (shiftLoadStb),
    .txDoneStb    (txDoneStb),
    .rxDoneStb    (rxDoneStb),
    .rxParityErr  (rxParityErr),
    .rxFrameErr   (rxFrameErr),
    .strb         (strb),
    .statusOut    (statusOut),
    .reqVec       (reqVec),
    .topValid     (irqTopValid),
    .topId        (topId)
  );

  sio_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cpuTxData   (cpuTxData),
    .rxByte      (rxByte),
    .txShiftData (txShiftData),
    .rxData      (rxData)
  );

  assign irqRxErr   = reqVec[SRC_ERR];
  assign irqRxFull  = reqVec[SRC_RXF];
  assign irqTxEmpty = reqVec[SRC_TXE];
  assign irqTxEnd   = reqVec[SRC_TEND];
  assign irqTopId   = topId;

  // R9: an error request always wins the priority code
  p_err_first_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqRxErr |-> (irqTopId == 2'd0));

  // R9: receive-full wins over both transmit requests
  p_rxf_second_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqRxFull && !irqRxErr) |-> (irqTopId == 2'd1));

  // R8: a request line is never active while the top-valid flag is low
  p_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    !irqTopValid |-> !(irqRxErr || irqRxFull || irqTxEmpty || irqTxEnd));
endmodule

// File: tb/sio_status_irq_bench.sv
module sio_status_irq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       cpuTxWrite = 0, cpuRxRead = 0, statWrite = 0, ctrlWrite = 0;
  logic [7:0] cpuTxData = 0, rxByte = 0;
  logic [2:0] statWrData = 0, ctrlWrData = 0;
  logic       shiftLoadStb = 0, txDoneStb = 0, rxDoneStb = 0;
  logic       rxParityErr = 0, rxFrameErr = 0;
  logic [7:0] txShiftData, rxData;
  logic [5:0] statusOut;
  logic       irqRxErr, irqRxFull, irqTxEmpty, irqTxEnd, irqTopValid;
  logic [1:0] irqTopId;

  sio_status_irq u_sio_status_irq (.*);

  int checks = 0, fails = 0;
  bit doneFlag = 0;

  typedef struct {
    string      tag;
    logic [5:0] st;
    logic [3:0] irq;
    logic       tv;
    logic [1:0] tid;
    logic [7:0] rxd;
    logic [7:0] txd;
  } exp_t;
  exp_t expQ[$];

  logic       mTxE, mTend, mRxf, mOvr, mPe, mFe;
  logic [2:0] mEn;
  logic [7:0] mRxd, mTxd;

  task automatic chk(string tag, string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s): actual %0h expected %0h", req, tag, act, exp);
    end
  endtask

  task automatic pushExp(string tag);
    exp_t e;
    logic [3:0] r;
    r[0] = mEn[1] & (mOvr | mPe | mFe);
    r[1] = mEn[1] & mRxf;
    r[2] = mEn[0] & mTxE;
    r[3] = mEn[2] & mTend;
    e.tag = tag;
    e.st  = {mFe, mPe, mOvr, mRxf, mTend, mTxE};
    e.irq = r;
    e.tv  = |r;
    e.tid = r[0] ? 2'd0 : r[1] ? 2'd1 : r[2] ? 2'd2 : r[3] ? 2'd3 : 2'd0;
    e.rxd = mRxd;
    e.txd = mTxd;
    expQ.push_back(e);
  endtask

  // driver: one call is one clock cycle of stimulus
  task automatic step(string tag, bit txW, logic [7:0] txD, bit rxR,
                      bit stW, logic [2:0] stD, bit ctW, logic [2:0] ctD,
                      bit ld, bit dn, bit rxDn, logic [7:0] rb, bit pe, bit fe);
    bit acc;
    @(negedge clk);
    cpuTxWrite = txW; cpuTxData = txD; cpuRxRead = rxR;
    statWrite = stW; statWrData = stD; ctrlWrite = ctW; ctrlWrData = ctD;
    shiftLoadStb = ld; txDoneStb = dn; rxDoneStb = rxDn; rxByte = rb;
    rxParityErr = pe; rxFrameErr = fe;
    acc = rxDn && (!mRxf || rxR);
    if (txW) begin mTxE = 0; mTend = 0; mTxd = txD; end
    else begin
      if (ld) mTxE = 1;
      if (dn) mTend = 1;
    end
    if (rxDn && !acc) mOvr = 1; else if (stW && !stD[0]) mOvr = 0;
    if (acc && pe) mPe = 1;     else if (stW && !stD[1]) mPe = 0;
    if (acc && fe) mFe = 1;     else if (stW && !stD[2]) mFe = 0;
    if (acc) begin mRxf = 1; mRxd = rb; end else if (rxR) mRxf = 0;
    if (ctW) mEn = ctD;
    pushExp(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 8'h00, 0, 0, 3'b111, 0, 3'b000, 0, 0, 0, 8'h00, 0, 0);
  endtask

  // monitor: compares after each edge with the expected item queued before it
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk(e.tag, "R2 txEmpty",   int'(statusOut[0]), int'(e.st[0]));
      chk(e.tag, "R3 txEnd",     int'(statusOut[1]), int'(e.st[1]));
      chk(e.tag, "R4 rxFull",    int'(statusOut[2]), int'(e.st[2]));
      chk(e.tag, "R5 overrun",   int'(statusOut[3]), int'(e.st[3]));
      chk(e.tag, "R6 parity",    int'(statusOut[4]), int'(e.st[4]));
      chk(e.tag, "R6 framing",   int'(statusOut[5]), int'(e.st[5]));
      chk(e.tag, "R8 requests",  int'({irqTxEnd, irqTxEmpty, irqRxFull, irqRxErr}), int'(e.irq));
      chk(e.tag, "R9 topValid",  int'(irqTopValid), int'(e.tv));
      if (e.tv) chk(e.tag, "R9 topId", int'(irqTopId), int'(e.tid));
      chk(e.tag, "R4 rxData",    int'(rxData), int'(e.rxd));
      chk(e.tag, "R2 txShiftData", int'(txShiftData), int'(e.txd));
    end
  end

  initial begin
    #(200000 * 8);
    if (!doneFlag) begin
      doneFlag = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mTxE = 1; mTend = 1; mRxf = 0; mOvr = 0; mPe = 0; mFe = 0;
    mEn = 0; mRxd = 0; mTxd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1: reset state, observed at the ports
    @(negedge clk);
    chk("reset", "R1 status", int'(statusOut), 6'b000011);
    chk("reset", "R1 requests", int'({irqTxEnd, irqTxEmpty, irqRxFull, irqRxErr, irqTopValid}), 0);

    // R8 R9: enable all, transmit requests appear, top is transmit empty
    step("enable all", 0, 0, 0, 0, 3'b111, 1, 3'b111, 0, 0, 0, 0, 0, 0);
    // R2 R3: write clears both transmit flags
    step("tx write", 1, 8'hA5, 0, 0, 3'b111, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: overwrite while not empty
    step("tx overwrite", 1, 8'h3C, 0, 0, 3'b111, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: shifter load sets empty, newest byte offered
    step("tx load", 0, 0, 0, 0, 3'b111, 0, 0, 1, 0, 0, 0, 0, 0);
    // R3: transmission finished
    step("tx done", 0, 0, 0, 0, 3'b111, 0, 0, 0, 1, 0, 0, 0, 0);
    // R4: first byte
    step("rx byte", 0, 0, 0, 0, 3'b111, 0, 0, 0, 0, 1, 8'h11, 0, 0);
    // R5 R6: overrun carrying a parity error, byte and error dropped
    step("rx overrun", 0, 0, 0, 0, 3'b111, 0, 0, 0, 0, 1, 8'h22, 1, 0);
    idle("hold");
    // R7: writing ones keeps flags, writing zero to bit0 clears overrun
    step("clr ones", 0, 0, 0, 1, 3'b111, 0, 0, 0, 0, 0, 0, 0, 0);
    step("clr ovr", 0, 0, 0, 1, 3'b110, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10: read and completion in one cycle
    step("rd+done", 0, 0, 1, 0, 3'b111, 0, 0, 0, 0, 1, 8'h33, 0, 0);
    // R4: read clears receive full
    step("rx read", 0, 0, 1, 0, 3'b111, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: accepted byte with both errors
    step("rx errs", 0, 0, 0, 0, 3'b111, 0, 0, 0, 0, 1, 8'h44, 1, 1);
    // R7: clear parity only, then framing
    step("clr pe", 0, 0, 0, 1, 3'b101, 0, 0, 0, 0, 0, 0, 0, 0);
    step("clr fe", 0, 0, 0, 1, 3'b011, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10: write collides with a shifter load
    step("wr+load", 1, 8'h5A, 0, 0, 3'b111, 0, 0, 1, 0, 0, 0, 0, 0);
    // R3: done in the same cycle as a write leaves transmit end low
    step("wr+done", 1, 8'h6B, 0, 0, 3'b111, 0, 0, 0, 1, 0, 0, 0, 0);
    step("load", 0, 0, 0, 0, 3'b111, 0, 0, 1, 0, 0, 0, 0, 0);
    // R8: transmit only, then receive only, then none
    step("en tx", 0, 0, 0, 0, 3'b111, 1, 3'b001, 0, 0, 0, 0, 0, 0);
    step("en rx", 0, 0, 0, 0, 3'b111, 1, 3'b010, 0, 0, 0, 0, 0, 0);
    step("en none", 0, 0, 0, 0, 3'b111, 1, 3'b000, 0, 0, 0, 0, 0, 0);
    // R9: end enable only, transmit end as sole source
    step("done", 0, 0, 0, 0, 3'b111, 1, 3'b100, 0, 1, 0, 0, 0, 0);
    idle("tail");
    idle("tail");
    @(negedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule